// File: doc/BRIEF.md
# Flash Page Buffer Read Controller

This controller sits between a simple single-outstanding bus slave port and a slow flash array. It keeps two page-wide read buffers (128 bits each, four 32-bit words) with one least-recently-used bit. A read that finds its page in a buffer completes with no wait-state. A read that misses holds the array read strobe for a programmable number of cycles. It then fills the victim buffer and returns the addressed word in the same step. Writes go straight to the array with their own programmable wait count, and they drop any buffer that holds the written page.

Each master has its own read and write permission bits. A request that breaks them never reaches the array. It gets a two-cycle error response instead. When prefetch is enabled and the bus falls idle after a read, the controller fetches the next sequential page into the least-recently-used buffer. That page stays least-recently-used until a later read hits it. Any newly accepted request aborts a prefetch that is still in flight.

Top module: `pageBufCtl`

## Requirements
- R1: After reset `hready` is 1, `hresp` is 0 and both `flashRd` and `flashWr` are 0.
- R2: A permitted read whose page is in no valid buffer keeps `flashRd` high with `flashPage` equal to the requested page (`wordAddr[13:2]`) and holds `hready` low for `rdWait`+1 cycles. It then gives one cycle with `hready`=1 and `hresp`=0 in which `rdata` is word `wordAddr[1:0]` of that page, and the page is now buffered.
- R3: A permitted read whose page is in a valid buffer completes in the cycle right after acceptance (`hready`=1, `hresp`=0, zero wait-states) with the addressed word, and raises no array strobe.
- R4: A permitted write holds `flashWr` high for `wrWait`+1 cycles with `hready` low, driving `flashPage`, `flashWord` and `flashWdata`. It then ends with `hready`=1 and `hresp`=0.
- R5: A permitted write to a page held in a buffer invalidates that buffer, so the next read of the page misses and returns the newly written array content.
- R6: A read from master m with `rdAllow[m]`=0, or a write with `wrAllow[m]`=0, gets `hresp`=1 with `hready`=0 in the first response cycle, then `hresp`=1 with `hready`=1 in the second. Neither `flashRd` nor `flashWr` is raised for it. The master issues no request in the second error cycle.
- R7: A demand miss fills the least-recently-used buffer and makes it most-recently-used. A read hit makes the hit buffer most-recently-used.
- R8: With `prefetchEn`=1, if after a permitted read the controller sees one idle cycle (state idle, `req`=0) and the next page is not buffered, it raises `flashRd` for the next page. `hready` stays 1 meanwhile, and after `rdWait`+1 cycles that page is buffered, so a read of it hits.
- R9: A prefetched page goes into the least-recently-used buffer and leaves the replacement bit unchanged, so the next demand miss evicts it.
- R10: A read hit on a prefetched page promotes it to most-recently-used.
- R11: A request accepted while a prefetch is in flight cancels it. The request is served as if from idle, and the prefetched page is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, accepted on an edge where `hready` is 1 (not in the second error cycle) |
| write | input | 1 | 1 = write, 0 = read |
| master | input | 2 | Requesting master index |
| wordAddr | input | 14 | 32-bit word address: [13:2] page, [1:0] word in page |
| wdata | input | 32 | Write data, sampled with the request |
| hready | output | 1 | Transfer done / ready for a new request |
| hresp | output | 1 | 1 = error response |
| rdata | output | 32 | Read data, valid when a read completes |
| rdAllow | input | 4 | Per-master read permission |
| wrAllow | input | 4 | Per-master write permission |
| rdWait | input | 4 | Read wait-states |
| wrWait | input | 4 | Write wait-states |
| prefetchEn | input | 1 | Enables next-page prefetch |
| flashRd | output | 1 | Array read strobe |
| flashWr | output | 1 | Array write strobe |
| flashPage | output | 12 | Array page address |
| flashWord | output | 2 | Word in page for writes |
| flashWdata | output | 32 | Array write data |
| flashRdata | input | 128 | Array page read data |

## Verification
A wrong tag, valid bit or replacement bit shows up at the ports as a wrong wait count on a later read. The count is `rdWait`+1 where zero was due, or the reverse, on the first read of a page that should or should not still be held. Sequences of three to five reads therefore pin each eviction choice, including the cases where a prefetched page must be evicted first or must survive after promotion. A stale buffer after a write shows as old data on the very next read. A protection fault that leaks into the array shows as an extra array strobe counted during that two-cycle response.

// File: rtl/pageBufPkg.sv
package pageBufPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_RDWAIT,
    ST_WRWAIT,
    ST_PFWAIT,
    ST_ERR1,
    ST_ERR2
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // latch request address / data
    logic hitLoad;    // capture hit word, promote hit buffer
    logic inval;      // drop buffer holding the written page
    logic demandFill; // install demand page as most-recently-used
    logic pfFill;     // install prefetched page, keep replacement bit
    logic selPf;      // array address comes from prefetch target
  } ctlStrobe_t;

endpackage

// File: rtl/pageBufData.sv
module pageBufData
  import pageBufPkg::*;
#(
  parameter int WADDR_W = 14,
  parameter int PAGE_W  = WADDR_W - 2,
  parameter int NBUF    = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobe_t                   strb,
  input  logic [PAGE_W-1:0]            busPage,
  input  logic [1:0]                   busWord,
  input  logic [31:0]                  busWdata,
  input  logic [127:0]                 flashRdata,
  output logic                         busHit,
  output logic                         pfHeld,
  output logic [31:0]                  rdData,
  output logic [PAGE_W-1:0]            flashPage,
  output logic [1:0]                   flashWord,
  output logic [31:0]                  flashWdata,
  output logic [NBUF-1:0]              validOut,
  output logic [NBUF-1:0][PAGE_W-1:0]  tagOut
);

  logic [127:0]      pageData [NBUF];
  logic [PAGE_W-1:0] tag      [NBUF];
  logic [NBUF-1:0]   valid;
  logic [NBUF-1:0]   hitVec;
  logic [NBUF-1:0]   pfVec;
  logic              lru;       // index of least-recently-used buffer
  logic              hitIdx;
  logic [PAGE_W-1:0] reqPage;
  logic [PAGE_W-1:0] pfPage;
  logic [1:0]        reqWord;
  logic [31:0]       wdataReg;
  logic [31:0]       hitWord;
  logic [31:0]       fillWord;

  for (genvar g = 0; g < NBUF; g++) begin : gLook
    assign hitVec[g] = valid[g] && (tag[g] == busPage);
    assign pfVec[g]  = valid[g] && (tag[g] == pfPage);
    assign tagOut[g] = tag[g];
  end

  assign busHit     = |hitVec;
  assign pfHeld     = |pfVec;
  assign hitIdx     = hitVec[1];
  assign hitWord    = pageData[hitIdx][{busWord, 5'b0} +: 32];
  assign fillWord   = flashRdata[{reqWord, 5'b0} +: 32];
  assign flashPage  = strb.selPf ? pfPage : reqPage;
  assign flashWord  = reqWord;
  assign flashWdata = wdataReg;
  assign validOut   = valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valid    <= '0;
      lru      <= 1'b0;
      rdData   <= '0;
      reqPage  <= '0;
      pfPage   <= '0;
      reqWord  <= '0;
      wdataReg <= '0;
    end else begin
      if (strb.accept) begin
        reqPage  <= busPage;
        reqWord  <= busWord;
        pfPage   <= busPage + 1'b1;
        wdataReg <= busWdata;
      end
      if (strb.hitLoad) begin
        rdData <= hitWord;
        lru    <= ~hitIdx;
      end
      for (int i = 0; i < NBUF; i++) begin
        if (strb.inval && hitVec[i]) valid[i] <= 1'b0;
      end
      if (strb.demandFill) begin
        valid[lru] <= 1'b1;
        rdData     <= fillWord;
        lru        <= ~lru;
      end
      if (strb.pfFill) valid[lru] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.demandFill) begin
      pageData[lru] <= flashRdata;
      tag[lru]      <= reqPage;
    end
    if (strb.pfFill) begin
      pageData[lru] <= flashRdata;
      tag[lru]      <= pfPage;
    end
  end

endmodule

// File: rtl/pageBufFsm.sv
module pageBufFsm
  import pageBufPkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int MID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  parameter int WAIT_W      = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   req,
  input  logic                   write,
  input  logic [MID_W-1:0]       master,
  input  logic [NUM_MASTERS-1:0] rdAllow,
  input  logic [NUM_MASTERS-1:0] wrAllow,
  input  logic [WAIT_W-1:0]      rdWait,
  input  logic [WAIT_W-1:0]      wrWait,
  input  logic                   prefetchEn,
  input  logic                   busHit,
  input  logic                   pfHeld,
  output ctlStrobe_t             strb,
  output logic                   hready,
  output logic                   hresp,
  output logic                   flashRd,
  output logic                   flashWr
);

  ctlState_t         st, stNext;
  logic [WAIT_W-1:0] cnt, cntNext;
  logic              pfArm, pfArmNext;
  logic              accept, allowed;

  always_comb begin
    accept  = req && (st == ST_IDLE || st == ST_DATA || st == ST_PFWAIT);
    allowed = write ? wrAllow[master] : rdAllow[master];

    strb            = '0;
    strb.accept     = accept;
    strb.hitLoad    = accept && allowed && !write && busHit;
    strb.inval      = accept && allowed && write;
    strb.demandFill = (st == ST_RDWAIT) && (cnt == rdWait);
    strb.pfFill     = (st == ST_PFWAIT) && !accept && (cnt == rdWait);
    strb.selPf      = (st == ST_PFWAIT);

    stNext    = st;
    cntNext   = cnt + 1'b1;
    pfArmNext = pfArm;
    if (accept) begin
      cntNext   = '0;
      pfArmNext = allowed && !write;
      if (!allowed)    stNext = ST_ERR1;
      else if (write)  stNext = ST_WRWAIT;
      else if (busHit) stNext = ST_DATA;
      else             stNext = ST_RDWAIT;
    end else begin
      unique case (st)
        ST_IDLE: begin
          pfArmNext = 1'b0;
          if (pfArm && prefetchEn && !pfHeld) begin
            stNext  = ST_PFWAIT;
            cntNext = '0;
          end
        end
        ST_DATA:   stNext = ST_IDLE;
        ST_RDWAIT: if (cnt == rdWait) stNext = ST_DATA;
        ST_WRWAIT: if (cnt == wrWait) stNext = ST_DATA;
        ST_PFWAIT: if (cnt == rdWait) stNext = ST_IDLE;
        ST_ERR1:   stNext = ST_ERR2;
        ST_ERR2:   stNext = ST_IDLE;
        default:   stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      pfArm <= 1'b0;
    end else begin
      st    <= stNext;
      cnt   <= cntNext;
      pfArm <= pfArmNext;
    end
  end

  assign hready  = (st == ST_IDLE) || (st == ST_DATA) || (st == ST_PFWAIT) || (st == ST_ERR2);
  assign hresp   = (st == ST_ERR1) || (st == ST_ERR2);
  assign flashRd = (st == ST_RDWAIT) || (st == ST_PFWAIT);
  assign flashWr = (st == ST_WRWAIT);

endmodule

// File: rtl/pageBufCtl.sv
module pageBufCtl
  import pageBufPkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int MID_W       = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
  parameter int WADDR_W     = 14,
  parameter int WAIT_W      = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   req,
  input  logic                   write,
  input  logic [MID_W-1:0]       master,
  input  logic [WADDR_W-1:0]     wordAddr,
  input  logic [31:0]            wdata,
  output logic                   hready,
  output logic                   hresp,
  output logic [31:0]            rdata,
  input  logic [NUM_MASTERS-1:0] rdAllow,
  input  logic [NUM_MASTERS-1:0] wrAllow,
  input  logic [WAIT_W-1:0]      rdWait,
  input  logic [WAIT_W-1:0]      wrWait,
  input  logic                   prefetchEn,
  output logic                   flashRd,
  output logic                   flashWr,
  output logic [WADDR_W-3:0]     flashPage,
  output logic [1:0]             flashWord,
  output logic [31:0]            flashWdata,
  input  logic [127:0]           flashRdata
);

  localparam int PAGE_W = WADDR_W - 2;
  localparam int NBUF   = 2;

  ctlStrobe_t                  strb;
  logic                        busHit;
  logic                        pfHeld;
  logic [NBUF-1:0]             validOut;
  logic [NBUF-1:0][PAGE_W-1:0] tagOut;

  pageBufFsm #(
    .NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W), .WAIT_W(WAIT_W)
  ) uFsm (
    .clk(clk), .rstN(rstN), .req(req), .write(write), .master(master),
    .rdAllow(rdAllow), .wrAllow(wrAllow), .rdWait(rdWait), .wrWait(wrWait),
    .prefetchEn(prefetchEn), .busHit(busHit), .pfHeld(pfHeld), .strb(strb),
    .hready(hready), .hresp(hresp), .flashRd(flashRd), .flashWr(flashWr)
  );

  pageBufData #(
    .WADDR_W(WADDR_W), .PAGE_W(PAGE_W), .NBUF(NBUF)
  ) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .busPage(wordAddr[WADDR_W-1:2]), .busWord(wordAddr[1:0]),
    .busWdata(wdata), .flashRdata(flashRdata), .busHit(busHit),
    .pfHeld(pfHeld), .rdData(rdata), .flashPage(flashPage),
    .flashWord(flashWord), .flashWdata(flashWdata),
    .validOut(validOut), .tagOut(tagOut)
  );

endmodule

// File: rtl/pageBufChk.sv
module pageBufChk #(
  parameter int PAGE_W = 12
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   hready,
  input logic                   hresp,
  input logic                   flashRd,
  input logic                   flashWr,
  input logic [PAGE_W-1:0]      flashPage,
  input logic                   accept,
  input logic                   hitLoad,
  input logic                   selPf,
  input logic [1:0]             validOut,
  input logic [1:0][PAGE_W-1:0] tagOut
);

  // R2: array address holds while one read is in progress
  p_rd_addr_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
    (flashRd && $past(flashRd) && !$past(accept)) |-> $stable(flashPage));

  // R3: a hit completes in the next cycle without error
  p_hit_zero_wait_r3: assert property (@(posedge clk) disable iff (!rstN)
    hitLoad |=> (hready && !hresp));

  // R4: a write strobe ends with an okay completion
  p_write_ok_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flashWr) |-> (hready && !hresp));

  // R6: error is two cycles, ready low then high
  p_err_two_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hresp && !hready) |=> (hresp && hready));

  // R6: no array activity during an error response
  p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    hresp |-> (!flashRd && !flashWr));

  // R7: two valid buffers never hold the same page
  p_tags_unique_r7: assert property (@(posedge clk) disable iff (!rstN)
    (&validOut) |-> (tagOut[0] != tagOut[1]));

  // R8: bus stays ready while a prefetch runs
  p_pf_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    selPf |-> (hready && flashRd));

  // R1: strobes mutually exclusive with each other and with error
  p_strobe_excl_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flashRd, flashWr, hresp}));

endmodule

bind pageBufCtl pageBufChk #(.PAGE_W(PAGE_W)) uChk (
  .clk(clk), .rstN(rstN), .hready(hready), .hresp(hresp),
  .flashRd(flashRd), .flashWr(flashWr), .flashPage(flashPage),
  .accept(strb.accept), .hitLoad(strb.hitLoad), .selPf(strb.selPf),
  .validOut(validOut), .tagOut(tagOut)
);

// File: tb/tb_pageBufCtl.sv
`timescale 1ns/1ps
module tb_pageBufCtl;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         req = 1'b0;
  logic         write = 1'b0;
  logic [1:0]   master = '0;
  logic [13:0]  wordAddr = '0;
  logic [31:0]  wdata = '0;
  logic         hready, hresp;
  logic [31:0]  rdata;
  logic [3:0]   rdAllow = 4'b1011;   // master 2 may not read
  logic [3:0]   wrAllow = 4'b1101;   // master 1 may not write
  logic [3:0]   rdWait = 4'd2;
  logic [3:0]   wrWait = 4'd3;
  logic         prefetchEn = 1'b0;
  logic         flashRd, flashWr;
  logic [11:0]  flashPage;
  logic [1:0]   flashWord;
  logic [31:0]  flashWdata;
  logic [127:0] flashRdata = '0;

  always #2.5 clk = ~clk;

  pageBufCtl dut (
    .clk(clk), .rstN(rstN), .req(req), .write(write), .master(master),
    .wordAddr(wordAddr), .wdata(wdata), .hready(hready), .hresp(hresp),
    .rdata(rdata), .rdAllow(rdAllow), .wrAllow(wrAllow), .rdWait(rdWait),
    .wrWait(wrWait), .prefetchEn(prefetchEn), .flashRd(flashRd),
    .flashWr(flashWr), .flashPage(flashPage), .flashWord(flashWord),
    .flashWdata(flashWdata), .flashRdata(flashRdata)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string reqTag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", reqTag, what, act, exp);
    end
  endtask

  // ---------------- flash array stub ----------------
  logic [31:0] ovr [int];
  int rdRise = 0;
  int wrCycles = 0;
  logic prevRd = 1'b0;

  function automatic logic [31:0] modelWord(input logic [13:0] wa);
    if (ovr.exists(int'(wa))) return ovr[int'(wa)];
    return {4'hA, wa[13:2], 8'h5C, 6'b0, wa[1:0]};
  endfunction

  always @(negedge clk) begin
    if (flashWr) begin
      ovr[int'({flashPage, flashWord})] = flashWdata;
      wrCycles++;
    end
    if (flashRd && !prevRd) rdRise++;
    prevRd = flashRd;
    for (int w = 0; w < 4; w++)
      flashRdata[w*32 +: 32] = modelWord({flashPage, w[1:0]});
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    bit          wr;
    bit          err;
    int          waits;
    logic [31:0] data;
    string       tag;
  } expItem_t;

  expItem_t q[$];
  int doneCnt = 0;

  initial begin
    forever begin
      expItem_t it;
      int waits;
      bit firstResp;
      bit first;
      wait (q.size() > 0);
      it = q[0];
      waits = 0;
      first = 1'b1;
      firstResp = 1'b0;
      forever begin
        @(negedge clk);
        if (first) firstResp = hresp;
        first = 1'b0;
        if (hready) break;
        waits++;
      end
      check(waits == it.waits, it.tag, "wait cycles", waits, it.waits);
      check(hresp == it.err, it.tag, "hresp", {31'b0, hresp}, {31'b0, it.err});
      if (it.err)
        check(firstResp == 1'b1, it.tag, "first error cycle hresp", {31'b0, firstResp}, 32'd1);
      if (!it.wr && !it.err)
        check(rdata == it.data, it.tag, "read data", rdata, it.data);
      void'(q.pop_front());
      doneCnt++;
    end
  end

  task automatic xfer(input int m, input bit wr, input logic [13:0] wa,
                      input logic [31:0] wd, input int expWaits,
                      input bit expErr, input string reqTag);
    expItem_t it;
    int ticket;
    @(negedge clk);
    req      = 1'b1;
    write    = wr;
    master   = m[1:0];
    wordAddr = wa;
    wdata    = wd;
    it.wr    = wr;
    it.err   = expErr;
    it.waits = expWaits;
    it.data  = modelWord(wa);
    it.tag   = reqTag;
    @(posedge clk);
    #1;
    req = 1'b0;
    ticket = doneCnt + 1;
    q.push_back(it);
    wait (doneCnt == ticket);
  endtask

  task automatic rd(input logic [13:0] wa, input int expWaits, input string reqTag);
    xfer(0, 1'b0, wa, 32'h0, expWaits, 1'b0, reqTag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int rise0, wr0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(hready == 1'b1, "R1", "hready in reset", {31'b0, hready}, 32'd1);
    check(hresp == 1'b0, "R1", "hresp in reset", {31'b0, hresp}, 32'd0);
    check(!flashRd && !flashWr, "R1", "array strobes in reset", {30'b0, flashRd, flashWr}, 32'd0);
    rstN = 1'b1;
    idle(2);
    check(hready && !hresp && !flashRd && !flashWr, "R1", "state after reset release",
          {29'b0, hready, hresp, flashRd | flashWr}, 32'h4);

    // R2: miss, rdWait=2 -> 3 wait cycles
    rise0 = rdRise;
    rd(14'h0041, 3, "R2");
    check(rdRise == rise0 + 1, "R2", "one array read on miss", rdRise, rise0 + 1);

    // R3: hit in same page
    rise0 = rdRise;
    rd(14'h0043, 0, "R3");
    check(rdRise == rise0, "R3", "no array read on hit", rdRise, rise0);

    // R4: write, wrWait=3 -> 4 cycles of write strobe
    wr0 = wrCycles;
    xfer(0, 1'b1, 14'h0042, 32'hDEAD_BEEF, 4, 1'b0, "R4");
    check(wrCycles == wr0 + 4, "R4", "write strobe cycles", wrCycles, wr0 + 4);

    // R5: buffered page was invalidated, new data returned
    rd(14'h0042, 3, "R5");

    // R6: read by master 2 and write by master 1 are refused
    rise0 = rdRise;
    wr0 = wrCycles;
    xfer(2, 1'b0, 14'h0042, 32'h0, 1, 1'b1, "R6");
    xfer(1, 1'b1, 14'h0042, 32'h1234_5678, 1, 1'b1, "R6");
    check(rdRise == rise0, "R6", "no array read on violation", rdRise, rise0);
    check(wrCycles == wr0, "R6", "no array write on violation", wrCycles, wr0);
    rd(14'h0042, 0, "R6");   // content unchanged, page still buffered

    // R7: demand replacement order
    rd(14'h0080, 3, "R7");   // pages 0x010, 0x020 held; 0x010 is LRU
    rd(14'h0040, 0, "R7");   // hit 0x010 -> 0x020 becomes LRU
    rd(14'h00C0, 3, "R7");   // miss evicts 0x020
    rd(14'h0041, 0, "R7");   // 0x010 survives
    rd(14'h0080, 3, "R7");   // 0x020 was evicted

    // R2: zero programmed read wait-states
    rdWait = 4'd0;
    rd(14'h0100, 1, "R2");
    rdWait = 4'd2;

    // R8: prefetch of next page during idle
    prefetchEn = 1'b1;
    rise0 = rdRise;
    rd(14'h0140, 3, "R8");
    idle(6);
    check(rdRise == rise0 + 2, "R8", "prefetch array read issued", rdRise, rise0 + 2);
    rd(14'h0145, 0, "R8");

    // R9: prefetched page stays LRU and is evicted first
    rd(14'h01C0, 3, "R9");
    idle(6);
    rd(14'h0240, 3, "R9");   // miss evicts prefetched 0x071
    rd(14'h01C0, 0, "R9");   // demand page survives
    rd(14'h01C4, 3, "R9");   // prefetched page is gone

    // R10: hit promotes a prefetched page
    rd(14'h0280, 3, "R10");
    idle(6);
    rd(14'h0284, 0, "R10");  // hit prefetched 0x0A1, promote
    rd(14'h0300, 3, "R10");  // evicts 0x0A0
    rd(14'h0285, 0, "R10");  // 0x0A1 survives
    rd(14'h0280, 3, "R10");  // 0x0A0 was evicted

    // R11: accepted request cancels prefetch in flight
    rd(14'h0340, 3, "R11");
    idle(1);
    @(posedge clk);
    #1;
    check(flashRd == 1'b1 && hready == 1'b1, "R11", "prefetch running with bus ready",
          {30'b0, flashRd, hready}, 32'h3);
    rd(14'h0380, 3, "R11");  // accepted during prefetch, full miss
    rd(14'h0344, 3, "R11");  // cancelled prefetch left nothing behind

    idle(2);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule